// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a compact processor core that completes one instruction per clock. In each cycle it presents the word index of the current program counter to an instruction memory and receives the 32-bit instruction back in the same cycle. It decodes that instruction and reads up to two operands from a 32-entry register file of 32-bit registers. It then computes a result, writes it back, and selects the next program counter.

Data memory is reached through a byte-addressed port. Reads are combinational. Writes commit on the rising clock edge while the write strobe is high. Only aligned whole words are transferred. The supported subset covers:
- three-operand register arithmetic and compare,
- immediate arithmetic and logic,
- upper-immediate loads for building wide constants,
- word load and store,
- two conditional branches relative to the program counter,
- one unconditional jump confined to the current 256 MB region.

Any other encoding executes as a no-op.

Top module: `mrc_core`

## Requirements
- R1: While `rst_n` is low, `imem_idx` is 0 and neither `dmem_we` nor `dmem_re` is asserted. The first instruction after reset is fetched from word index 0.
- R2: Opcode 15 (upper immediate) writes `{imm16, 16'h0}` to register rt. Opcode 13 (OR immediate) then fills the lower 16 bits, so the pair can build any 32-bit constant.
- R3: Opcodes 8 (add immediate), 10, 35, 43 and both branches sign-extend the 16-bit field. Opcodes 12 (AND immediate) and 13 zero-extend it.
- R4: R-type is opcode 0 with fields rs[25:21], rt[20:16], rd[15:11] and funct[5:0]. Funct 32 writes rs+rt to rd and funct 34 writes rs-rt to rd. Both wrap modulo 2^32.
- R5: R-type funct 42 writes 1 to rd when rs is less than rt as signed two's complement values, otherwise 0. Opcode 10 does the same comparison of rs against the immediate and writes rt.
- R6: Register 0 always reads as zero, and writes to it are discarded.
- R7: Opcode 35 (load) and opcode 43 (store) use the address rs plus the sign-extended immediate. A load writes `dmem_rdata` to rt. A store drives rt on `dmem_wdata` with `dmem_we` high. `dmem_we` is high only for stores, `dmem_re` only for loads, and never both together.
- R8: Opcode 4 branches when rs equals rt and opcode 5 branches when they differ. When taken, the next PC is PC+4 plus the sign-extended 16-bit field shifted left by 2. This works in both directions.
- R9: Opcode 2 jumps to `{PC+4[31:28], target26, 2'b00}`. A jump to its own address holds the PC there.
- R10: An unsupported opcode, or an unsupported R-type funct, changes no register, performs no memory access, and advances the PC by 4.
- R11: Every instruction other than a taken branch or a jump advances the PC by exactly 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| imem_idx | output | 30 | Word index of the instruction being fetched (PC bits 31:2) |
| imem_rdata | input | 32 | Instruction at `imem_idx`, valid in the same cycle |
| dmem_addr | output | 32 | Byte address of the data access |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, committed at the clock edge |
| dmem_re | output | 1 | Load indicator |
| dmem_rdata | input | 32 | Load data for `dmem_addr`, valid in the same cycle |

## Verification
The assertions assume that the instruction memory returns a defined word for every index the core fetches. They also assume that load data at `dmem_addr` is defined whenever `dmem_re` is high. The bench keeps within these assumptions in two ways:
- The fetch window is a 64-word array filled with defined words; entries beyond the program hold zero, which decodes as an unsupported R-type funct.
- The data array has every word set to zero before reset is released.

All test programs use base registers and offsets that give word-aligned addresses inside that array. Each program ends in a self-jump, so fetches never leave the window.

// File: rtl/mrc_pkg.sv
package mrc_pkg;

    parameter int unsigned XLEN = 32;
    parameter int unsigned NREG = 32;
    localparam int unsigned RIDX = $clog2(NREG);
    localparam int unsigned IMMW = 16;
    localparam int unsigned TGTW = 26;
    localparam int unsigned REGIONW = XLEN - TGTW - 2;

    localparam logic [5:0] OP_RTYPE = 6'd0;
    localparam logic [5:0] OP_JUMP  = 6'd2;
    localparam logic [5:0] OP_BEQ   = 6'd4;
    localparam logic [5:0] OP_BNE   = 6'd5;
    localparam logic [5:0] OP_ADDI  = 6'd8;
    localparam logic [5:0] OP_SLTI  = 6'd10;
    localparam logic [5:0] OP_ANDI  = 6'd12;
    localparam logic [5:0] OP_ORI   = 6'd13;
    localparam logic [5:0] OP_LUI   = 6'd15;
    localparam logic [5:0] OP_LW    = 6'd35;
    localparam logic [5:0] OP_SW    = 6'd43;

    localparam logic [5:0] FN_ADD = 6'd32;
    localparam logic [5:0] FN_SUB = 6'd34;
    localparam logic [5:0] FN_SLT = 6'd42;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_SLT,
        ALU_AND,
        ALU_OR,
        ALU_PASSB
    } alu_op_e;

    typedef enum logic [1:0] {
        IMM_SEXT,
        IMM_ZEXT,
        IMM_UPPER
    } imm_kind_e;

    typedef struct packed {
        alu_op_e   alu_op;
        logic      use_imm;
        imm_kind_e imm_kind;
        logic      reg_we;
        logic      dst_rd;
        logic      mem_rd;
        logic      mem_wr;
        logic      br_eq;
        logic      br_ne;
        logic      jump;
    } ctrl_t;

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_state_t;

endpackage

// File: rtl/mrc_decode.sv
module mrc_decode
    import mrc_pkg::*;
(
    input  logic [31:0]     instr,
    output ctrl_t           ctrl,
    output logic [RIDX-1:0] rs_idx,
    output logic [RIDX-1:0] rt_idx,
    output logic [RIDX-1:0] wr_idx,
    output logic [XLEN-1:0] imm_ext,
    output logic [TGTW-1:0] tgt
);

    logic [5:0]      opcode;
    logic [5:0]      funct;
    logic [IMMW-1:0] imm16;
    logic [RIDX-1:0] rd_idx;

    assign opcode = instr[31:26];
    assign funct  = instr[5:0];
    assign imm16  = instr[IMMW-1:0];
    assign rs_idx = instr[25:21];
    assign rt_idx = instr[20:16];
    assign rd_idx = instr[15:11];
    assign tgt    = instr[TGTW-1:0];

    always_comb begin
        ctrl          = '0;
        ctrl.alu_op   = ALU_ADD;
        ctrl.imm_kind = IMM_SEXT;
        unique case (opcode)
            OP_RTYPE: begin
                ctrl.dst_rd = 1'b1;
                unique case (funct)
                    FN_ADD: begin ctrl.alu_op = ALU_ADD; ctrl.reg_we = 1'b1; end
                    FN_SUB: begin ctrl.alu_op = ALU_SUB; ctrl.reg_we = 1'b1; end
                    FN_SLT: begin ctrl.alu_op = ALU_SLT; ctrl.reg_we = 1'b1; end
                    default: ctrl.reg_we = 1'b0;
                endcase
            end
            OP_ADDI: begin
                ctrl.use_imm = 1'b1;
                ctrl.reg_we  = 1'b1;
            end
            OP_SLTI: begin
                ctrl.alu_op  = ALU_SLT;
                ctrl.use_imm = 1'b1;
                ctrl.reg_we  = 1'b1;
            end
            OP_ANDI: begin
                ctrl.alu_op   = ALU_AND;
                ctrl.use_imm  = 1'b1;
                ctrl.imm_kind = IMM_ZEXT;
                ctrl.reg_we   = 1'b1;
            end
            OP_ORI: begin
                ctrl.alu_op   = ALU_OR;
                ctrl.use_imm  = 1'b1;
                ctrl.imm_kind = IMM_ZEXT;
                ctrl.reg_we   = 1'b1;
            end
            OP_LUI: begin
                ctrl.alu_op   = ALU_PASSB;
                ctrl.use_imm  = 1'b1;
                ctrl.imm_kind = IMM_UPPER;
                ctrl.reg_we   = 1'b1;
            end
            OP_LW: begin
                ctrl.use_imm = 1'b1;
                ctrl.reg_we  = 1'b1;
                ctrl.mem_rd  = 1'b1;
            end
            OP_SW: begin
                ctrl.use_imm = 1'b1;
                ctrl.mem_wr  = 1'b1;
            end
            OP_BEQ:  ctrl.br_eq = 1'b1;
            OP_BNE:  ctrl.br_ne = 1'b1;
            OP_JUMP: ctrl.jump  = 1'b1;
            default: ctrl.reg_we = 1'b0;
        endcase
    end

    assign wr_idx = ctrl.dst_rd ? rd_idx : rt_idx;

    always_comb begin
        unique case (ctrl.imm_kind)
            IMM_ZEXT:  imm_ext = {{(XLEN-IMMW){1'b0}}, imm16};
            IMM_UPPER: imm_ext = {imm16, {(XLEN-IMMW){1'b0}}};
            default:   imm_ext = {{(XLEN-IMMW){imm16[IMMW-1]}}, imm16};
        endcase
    end

endmodule

// File: rtl/mrc_regfile.sv
module mrc_regfile
    import mrc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RIDX-1:0] ra_idx,
    input  logic [RIDX-1:0] rb_idx,
    output logic [XLEN-1:0] ra_val,
    output logic [XLEN-1:0] rb_val,
    input  logic            we,
    input  logic [RIDX-1:0] w_idx,
    input  logic [XLEN-1:0] w_val
);

    logic [XLEN-1:0] regs_d [NREG];
    logic [XLEN-1:0] regs_q [NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            regs_d[i] = regs_q[i];
        end
        if (we && (w_idx != '0)) begin
            regs_d[w_idx] = w_val;
        end
        regs_d[0] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NREG; i++) begin
                regs_q[i] <= regs_d[i];
            end
        end
    end

    assign ra_val = (ra_idx == '0) ? '0 : regs_q[ra_idx];
    assign rb_val = (rb_idx == '0) ? '0 : regs_q[rb_idx];

endmodule

// File: rtl/mrc_alu.sv
module mrc_alu
    import mrc_pkg::*;
(
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);

    always_comb begin
        unique case (op)
            ALU_SUB:   y = a - b;
            ALU_SLT:   y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            ALU_AND:   y = a & b;
            ALU_OR:    y = a | b;
            ALU_PASSB: y = b;
            default:   y = a + b;
        endcase
    end

endmodule

// File: rtl/mrc_core.sv
module mrc_core
    import mrc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-3:0] imem_idx,
    input  logic [31:0]     imem_rdata,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    output logic            dmem_we,
    output logic            dmem_re,
    input  logic [XLEN-1:0] dmem_rdata
);

    core_state_t     st_d;
    core_state_t     st_q;
    ctrl_t           ctrl;
    logic [RIDX-1:0] rs_idx;
    logic [RIDX-1:0] rt_idx;
    logic [RIDX-1:0] wr_idx;
    logic [XLEN-1:0] imm_ext;
    logic [TGTW-1:0] tgt;
    logic [XLEN-1:0] rs_val;
    logic [XLEN-1:0] rt_val;
    logic [XLEN-1:0] alu_b;
    logic [XLEN-1:0] alu_y;
    logic [XLEN-1:0] wb_val;
    logic [XLEN-1:0] pc_plus4;
    logic [XLEN-1:0] br_target;
    logic [XLEN-1:0] jmp_target;
    logic            br_taken;

    mrc_decode u_dec (
        .instr   (imem_rdata),
        .ctrl    (ctrl),
        .rs_idx  (rs_idx),
        .rt_idx  (rt_idx),
        .wr_idx  (wr_idx),
        .imm_ext (imm_ext),
        .tgt     (tgt)
    );

    mrc_regfile u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .ra_idx (rs_idx),
        .rb_idx (rt_idx),
        .ra_val (rs_val),
        .rb_val (rt_val),
        .we     (ctrl.reg_we & rst_n),
        .w_idx  (wr_idx),
        .w_val  (wb_val)
    );

    assign alu_b = ctrl.use_imm ? imm_ext : rt_val;

    mrc_alu u_alu (
        .op (ctrl.alu_op),
        .a  (rs_val),
        .b  (alu_b),
        .y  (alu_y)
    );

    assign wb_val     = ctrl.mem_rd ? dmem_rdata : alu_y;
    assign dmem_addr  = alu_y;
    assign dmem_wdata = rt_val;
    assign dmem_we    = ctrl.mem_wr & rst_n;
    assign dmem_re    = ctrl.mem_rd & rst_n;

    assign pc_plus4   = st_q.pc + XLEN'(4);
    assign br_target  = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
    assign jmp_target = {pc_plus4[XLEN-1:XLEN-REGIONW], tgt, 2'b00};
    assign br_taken   = (ctrl.br_eq && (rs_val == rt_val)) ||
                        (ctrl.br_ne && (rs_val != rt_val));

    always_comb begin
        st_d = st_q;
        if (ctrl.jump) begin
            st_d.pc = jmp_target;
        end else if (br_taken) begin
            st_d.pc = br_target;
        end else begin
            st_d.pc = pc_plus4;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign imem_idx = st_q.pc[XLEN-1:2];

endmodule

// File: rtl/mrc_core_chk.sv
module mrc_core_chk
    import mrc_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-3:0] imem_idx,
    input logic [31:0]     imem_rdata,
    input logic [XLEN-1:0] dmem_addr,
    input logic            dmem_we,
    input logic            dmem_re,
    input logic [XLEN-1:0] rs_val
);

    logic [5:0]      op_now;
    logic [XLEN-1:0] sext_now;

    assign op_now   = imem_rdata[31:26];
    assign sext_now = {{(XLEN-IMMW){imem_rdata[IMMW-1]}}, imem_rdata[IMMW-1:0]};

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!dmem_we && !dmem_re && imem_idx == '0));

    // R7
    store_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> (op_now == OP_SW));

    // R7
    load_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_re |-> (op_now == OP_LW));

    // R7
    mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dmem_we && dmem_re));

    // R7
    mem_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dmem_we || dmem_re) |-> (dmem_addr == rs_val + sext_now));

    // R6
    zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (imem_rdata[25:21] == '0) |-> (rs_val == '0));

    // R11
    seq_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_now) != OP_JUMP && $past(op_now) != OP_BEQ &&
         $past(op_now) != OP_BNE) |-> (imem_idx == $past(imem_idx) + 1'b1));

    // R9
    jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_now) == OP_JUMP) |->
        (imem_idx == {$past(imem_idx + 1'b1) >> TGTW, $past(imem_rdata[TGTW-1:0])}));

endmodule

bind mrc_core mrc_core_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_idx   (imem_idx),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_we    (dmem_we),
    .dmem_re    (dmem_re),
    .rs_val     (rs_val)
);

// File: tb/mrc_core_tb.sv
module mrc_core_tb;

    typedef struct {
        logic [31:0] addr;
        logic [31:0] data;
        string       tag;
    } store_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [29:0] imem_idx;
    logic [31:0] imem_rdata;
    logic [31:0] dmem_addr;
    logic [31:0] dmem_wdata;
    logic        dmem_we;
    logic        dmem_re;
    logic [31:0] dmem_rdata;

    logic [31:0] imem [64];
    logic [31:0] dmem [64];
    store_t      exp_q [$];
    int          n_chk = 0;
    int          n_fail = 0;
    int          pc_n = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    mrc_core u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_idx   (imem_idx),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_re    (dmem_re),
        .dmem_rdata (dmem_rdata)
    );

    assign imem_rdata = imem[imem_idx[5:0]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    always @(posedge clk) begin
        if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
    end

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    function automatic logic [31:0] enc_j(int target);
        return {6'd2, 26'(target)};
    endfunction

    task automatic emit(logic [31:0] w);
        imem[pc_n] = w;
        pc_n++;
    endtask

    task automatic drive_store(logic [31:0] a, logic [31:0] d, string tag);
        store_t s;
        s.addr = a;
        s.data = d;
        s.tag  = tag;
        exp_q.push_back(s);
    endtask

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every store
    always @(negedge clk) begin
        if (rst_n && dmem_we && !done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 unexpected store", dmem_addr, 32'hFFFFFFFF);
            end else begin
                store_t s;
                s = exp_q.pop_front();
                check(dmem_addr == s.addr, {s.tag, " addr"}, dmem_addr, s.addr);
                check(dmem_wdata == s.data, {s.tag, " data"}, dmem_wdata, s.data);
            end
        end
    end

    initial begin
        #(8 * 200000);
        check(1'b0, "watchdog", 32'd0, 32'd1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            imem[i] = 32'h0;
            dmem[i] = 32'h0;
        end
        // R2 constant build
        emit(enc_i(6'd15, 0, 1, 16'h1234));
        emit(enc_i(6'd13, 1, 1, 16'h5678));
        emit(enc_i(6'd43, 0, 1, 16'd0));
        drive_store(32'd0, 32'h12345678, "R2");
        // R3 sign and zero extension
        emit(enc_i(6'd8, 0, 2, 16'hFFFB));
        emit(enc_i(6'd43, 0, 2, 16'd4));
        drive_store(32'd4, 32'hFFFFFFFB, "R3 sext");
        emit(enc_i(6'd12, 2, 3, 16'hF0F0));
        emit(enc_i(6'd43, 0, 3, 16'd8));
        drive_store(32'd8, 32'h0000F0F0, "R3 zext");
        // R5 signed compares
        emit(enc_r(2, 1, 4, 6'd42));
        emit(enc_i(6'd43, 0, 4, 16'd12));
        drive_store(32'd12, 32'd1, "R5 slt");
        emit(enc_i(6'd10, 1, 5, 16'hFFFF));
        emit(enc_i(6'd43, 0, 5, 16'd16));
        drive_store(32'd16, 32'd0, "R5 slti false");
        emit(enc_i(6'd10, 2, 10, 16'hFFFC));
        emit(enc_i(6'd43, 0, 10, 16'd60));
        drive_store(32'd60, 32'd1, "R5 slti true");
        // R4 add and sub
        emit(enc_r(1, 2, 6, 6'd34));
        emit(enc_i(6'd43, 0, 6, 16'd20));
        drive_store(32'd20, 32'h1234567D, "R4 sub");
        emit(enc_r(2, 2, 11, 6'd32));
        emit(enc_i(6'd43, 0, 11, 16'd64));
        drive_store(32'd64, 32'hFFFFFFF6, "R4 add");
        // R6 write to register 0 discarded
        emit(enc_r(1, 1, 0, 6'd32));
        emit(enc_i(6'd43, 0, 0, 16'd24));
        drive_store(32'd24, 32'd0, "R6");
        // R7 load then store with a non-zero base
        emit(enc_i(6'd35, 0, 7, 16'd0));
        emit(enc_i(6'd8, 0, 8, 16'd28));
        emit(enc_i(6'd43, 8, 7, 16'd4));
        drive_store(32'd32, 32'h12345678, "R7");
        // R8 taken beq skips one store
        emit(enc_i(6'd4, 1, 1, 16'd1));
        emit(enc_i(6'd43, 0, 1, 16'd36));
        emit(enc_i(6'd43, 0, 2, 16'd40));
        drive_store(32'd40, 32'hFFFFFFFB, "R8 beq taken");
        // R8 bne not taken
        emit(enc_i(6'd5, 1, 1, 16'd1));
        emit(enc_i(6'd43, 0, 3, 16'd44));
        drive_store(32'd44, 32'h0000F0F0, "R8 bne not taken");
        // R8 bne taken skips one store
        emit(enc_i(6'd5, 1, 2, 16'd1));
        emit(enc_i(6'd43, 0, 0, 16'd48));
        // R10 unsupported opcode
        emit(32'hFC00_0000);
        emit(enc_i(6'd43, 0, 3, 16'd48));
        drive_store(32'd48, 32'h0000F0F0, "R10");
        // R9 forward jump skips one store
        emit(enc_j(pc_n + 2));
        emit(enc_i(6'd43, 0, 1, 16'd52));
        emit(enc_i(6'd43, 0, 4, 16'd52));
        drive_store(32'd52, 32'd1, "R9 jump");
        // R8 backward branch loop
        emit(enc_i(6'd8, 0, 9, 16'd3));
        emit(enc_i(6'd8, 9, 9, 16'hFFFF));
        emit(enc_i(6'd43, 0, 9, 16'd56));
        emit(enc_i(6'd5, 9, 0, 16'hFFFD));
        drive_store(32'd56, 32'd2, "R8 loop");
        drive_store(32'd56, 32'd1, "R8 loop");
        drive_store(32'd56, 32'd0, "R8 loop");
        // R9 self jump holds the PC
        emit(enc_j(pc_n));

        repeat (3) @(negedge clk);
        check(imem_idx == 30'd0, "R1 reset pc", 32'(imem_idx), 32'd0);
        check(!dmem_we && !dmem_re, "R1 reset mem", {30'd0, dmem_we, dmem_re}, 32'd0);
        rst_n = 1'b1;
        check(imem_idx == 30'd0, "R1 first fetch", 32'(imem_idx), 32'd0);

        for (int c = 0; c < 2000 && exp_q.size() != 0; c++) @(negedge clk);
        check(exp_q.size() == 0, "R11 stores outstanding", 32'(exp_q.size()), 32'd0);

        repeat (2) @(negedge clk);
        begin
            logic [29:0] held;
            held = imem_idx;
            check(held == 30'(pc_n - 1), "R9 self jump addr", 32'(held), 32'(pc_n - 1));
            repeat (3) @(negedge clk);
            check(imem_idx == held, "R9 pc held", 32'(imem_idx), 32'(held));
        end
        check(dmem[14] == 32'd0, "R8 loop final", dmem[14], 32'd0);
        check(dmem[9] == 32'd0, "R8 skipped store", dmem[9], 32'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule